// File: doc/BRIEF.md
# Host Data Port Burst Engine

This block gives a host a 16-bit window into the memories of a coprocessor. The host programs a word address and a configuration word, then moves data through a single data port. A write to the data port becomes one write request on a simple memory request interface, aimed at the region that the configuration selects. Reads are prefetched. A burst is started from the configuration register, and words are fetched ahead into a 16-entry read FIFO. Each host read of the data port takes the oldest prefetched word.

The burst length comes from a two-bit field in the status word: one word, eight words, sixteen words or endless. While a burst still has words left, the engine keeps the FIFO topped up toward sixteen entries, and never fetches past the remaining count of a bounded burst. A configuration write with the burst bit clear stops the burst and discards the FIFO. Each data-port access can step the address by one, wrapping at 16 bits. A one-cycle interrupt pulse marks data writes, burst starts and reads that leave data behind.

The memory side uses a valid/ready pair. A read response is taken in the same cycle as the accepted request. A posted write is held until the memory accepts it and takes priority over prefetch.

Top module: `hwin_burst_port`

## Requirements
- R1: After reset the status word reads 0x0100, the configuration reads 0, no memory request is raised and the interrupt is low.
- R2: Configuration bits 14:12 pick the region driven on `mem_region`: code 0 data memory, 1 register space, 5 program memory, 7 external bus. For code 1 the request address keeps only address bits 10:0 and forces bits 15:11 to zero. For the other valid codes it is the full address register.
- R3: With any other region code, a data-port write raises no request, leaves the address unchanged and raises no interrupt. Prefetch issues no request.
- R4: When configuration bit 1 is set, each accepted data-port write and each prefetched word add one to the address, wrapping from 0xFFFF to 0x0000. When bit 1 is clear, the address does not change.
- R5: A data-port write (offset 0x00) appears as exactly one write request carrying the address and data current at the write. The request stays valid and stable until `mem_ready`.
- R6: Status bits 3:2, written at offset 0x0C, choose the burst length: 0 gives 1 word, 1 gives 8, 2 gives 16 and 3 gives unbounded. A bounded burst fetches no more words than its length.
- R7: A configuration write (offset 0x08) with bit 4 set loads the burst count and starts prefetching. Fetching pauses while the FIFO holds 16 words.
- R8: A data-port read returns the oldest prefetched word and removes it. Words arrive in address order, and the FIFO is refilled only while burst words remain.
- R9: A data-port read with an empty FIFO returns 0.
- R10: A configuration write with bit 4 clear stops fetching and empties the FIFO.
- R11: Status bit 5 is set when the FIFO is full. Bits 6 and 0 are both set when it is non-empty. Bit 8 is always 1. Bits 3:2 read back the length select. All other status bits are 0.
- R12: `host_irq` pulses for one cycle in the cycle after an accepted data-port write, after a burst start, or after a data-port read that leaves the FIFO non-empty.
- R13: The address register at offset 0x04 is write-only and reads as 0. The configuration register reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_addr | input | 6 | Register byte offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data, valid in the strobe cycle |
| host_irq | output | 1 | One-cycle interrupt pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 for write, 0 for read |
| mem_region | output | 3 | Target region code |
| mem_addr | output | 16 | Word address in the region |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with an accepted read |

## Verification
The assertions assume that the host never writes the data port while an earlier posted write is still waiting for `mem_ready`. They also assume that it does not write the data port while a burst is fetching, so that only one source steps the address in a cycle. The stimulus meets the first assumption by leaving several idle cycles after every data write, with a memory that stalls at most one cycle in three. It meets the second by cancelling every burst before the next data-port write. The read response is taken as valid in the cycle of the handshake, and the bench memory returns a value derived from region and address.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
  localparam int unsigned WORD_W   = 16;
  localparam int unsigned OFS_W    = 6;
  localparam int unsigned RGN_W    = 3;
  localparam int unsigned REGS_AW  = 11;

  localparam logic [OFS_W-1:0] OFS_DATA = 6'h00;
  localparam logic [OFS_W-1:0] OFS_ADDR = 6'h04;
  localparam logic [OFS_W-1:0] OFS_CFG  = 6'h08;
  localparam logic [OFS_W-1:0] OFS_STAT = 6'h0C;

  localparam int unsigned CFG_INC_BIT   = 1;
  localparam int unsigned CFG_BURST_BIT = 4;
  localparam int unsigned CFG_RGN_LSB   = 12;

  localparam logic [RGN_W-1:0] RGN_DATA = 3'd0;
  localparam logic [RGN_W-1:0] RGN_REGS = 3'd1;
  localparam logic [RGN_W-1:0] RGN_PROG = 3'd5;
  localparam logic [RGN_W-1:0] RGN_EXT  = 3'd7;

  localparam logic [1:0] LEN_ENDLESS = 2'd3;

  typedef struct packed {
    logic [RGN_W-1:0]  rgn;
    logic [WORD_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } mem_cmd_t;

  function automatic logic region_ok(input logic [RGN_W-1:0] r);
    return (r == RGN_DATA) || (r == RGN_REGS) || (r == RGN_PROG) || (r == RGN_EXT);
  endfunction

  function automatic logic [WORD_W-1:0] map_addr(input logic [RGN_W-1:0] r,
                                                 input logic [WORD_W-1:0] a);
    logic [WORD_W-1:0] mask;
    mask = WORD_W'((1 << REGS_AW) - 1);
    return (r == RGN_REGS) ? (a & mask) : a;
  endfunction

  function automatic logic [WORD_W-1:0] step_addr(input logic [WORD_W-1:0] a,
                                                  input logic inc);
    return a + WORD_W'(inc);
  endfunction

  // Word count for a length select; the endless code yields 0 and is flagged apart.
  function automatic int unsigned burst_words(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 8;
      2'd2:    return 16;
      default: return 0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] make_status(input logic [1:0] len_sel,
                                                    input logic full,
                                                    input logic empty);
    logic [WORD_W-1:0] s;
    s      = '0;
    s[8]   = 1'b1;
    s[6]   = !empty;
    s[5]   = full;
    s[3:2] = len_sel;
    s[0]   = !empty;
    return s;
  endfunction
endpackage

// File: rtl/hwin_rdfifo.sv
module hwin_rdfifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 push_data,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full,
  output logic                         empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = $clog2(DEPTH+1);

  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (level_q == LVL_W'(DEPTH));
  assign empty   = (level_q == '0);
  assign level   = level_q;
  assign head    = store[rd_ptr_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) store[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else if (flush) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      level_q <= level_q + LVL_W'(do_push) - LVL_W'(do_pop);
    end
  end

  // R7: the prefetch side never offers a word to a full FIFO
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full)
    else $error("prefetch pushed into a full FIFO");

  // R10: a flush leaves the FIFO empty in the next cycle
  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty)
    else $error("FIFO not empty after flush");
endmodule

// File: rtl/hwin_burst_ctl.sv
module hwin_burst_ctl #(
  parameter int unsigned MAX_WORDS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cancel,
  input  logic [1:0] len_sel,
  input  logic       fetch_done,
  output logic       active
);
  import hwin_pkg::*;
  localparam int unsigned CNT_W = $clog2(MAX_WORDS+1);

  logic [CNT_W-1:0] remain_q;
  logic             endless_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q  <= '0;
      endless_q <= 1'b0;
    end else if (cancel) begin
      remain_q  <= '0;
      endless_q <= 1'b0;
    end else if (start) begin
      endless_q <= (len_sel == LEN_ENDLESS);
      remain_q  <= CNT_W'(burst_words(len_sel));
    end else if (fetch_done && !endless_q && (remain_q != '0)) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign active = endless_q || (remain_q != '0);

  // R6: a word is fetched only while the burst has words left
  p_fetch_in_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |-> active)
    else $error("word fetched with no burst remaining");

  // R10: cancel ends the burst in the next cycle
  p_cancel_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !start) |=> !active)
    else $error("burst still active after cancel");
endmodule

// File: rtl/hwin_mem_port.sv
module hwin_mem_port
  import hwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  mem_cmd_t          wr_cmd,
  input  logic              fetch_req,
  input  logic [RGN_W-1:0]  fetch_rgn,
  input  logic [WORD_W-1:0] fetch_addr,
  output logic              wr_busy,
  output logic              fetch_done,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [RGN_W-1:0]  mem_region,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata
);
  logic     pend_q;
  mem_cmd_t pend_cmd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_cmd_q <= '0;
    end else if (wr_go) begin
      pend_q     <= 1'b1;
      pend_cmd_q <= wr_cmd;
    end else if (pend_q && mem_ready) begin
      pend_q <= 1'b0;
    end
  end

  // A posted write has priority over prefetch.
  assign wr_busy    = pend_q;
  assign mem_valid  = pend_q || fetch_req;
  assign mem_write  = pend_q;
  assign mem_region = pend_q ? pend_cmd_q.rgn  : fetch_rgn;
  assign mem_addr   = pend_q ? pend_cmd_q.addr : fetch_addr;
  assign mem_wdata  = pend_q ? pend_cmd_q.data : '0;
  assign fetch_done = fetch_req && !pend_q && mem_ready;

  // R5: a stalled write keeps its request stable
  p_write_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !mem_ready) |=>
      (mem_valid && mem_write && $stable(mem_addr) && $stable(mem_wdata) && $stable(mem_region)))
    else $error("write request changed before acceptance");
endmodule

// File: rtl/hwin_burst_port.sv
module hwin_burst_port
  import hwin_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [5:0]        host_addr,
  input  logic [15:0]       host_wdata,
  output logic [15:0]       host_rdata,
  output logic              host_irq,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [2:0]        mem_region,
  output logic [15:0]       mem_addr,
  output logic [15:0]       mem_wdata,
  input  logic [15:0]       mem_rdata
);
  localparam int unsigned LVL_W = $clog2(FIFO_DEPTH+1);

  logic [WORD_W-1:0] cfg_q, addr_q;
  logic [1:0]        len_sel_q;
  logic              irq_q;

  logic              sel_data, sel_addr, sel_cfg, sel_stat;
  logic [RGN_W-1:0]  cfg_rgn;
  logic              cfg_inc, rgn_valid;

  // named internal events
  logic ev_data_wr, ev_data_rd, ev_addr_wr, ev_cfg_wr, ev_stat_wr;
  logic ev_burst_start, ev_burst_cancel, ev_fetch_done, ev_access;

  logic              burst_active, fetch_req, wr_busy;
  logic              fifo_full, fifo_empty, fifo_pop;
  logic [WORD_W-1:0] fifo_head;
  logic [LVL_W-1:0]  fifo_level, level_after;
  mem_cmd_t          wr_cmd;

  function automatic logic [LVL_W-1:0] level_next(input logic [LVL_W-1:0] lvl,
                                                  input logic pop, input logic push,
                                                  input logic full);
    return lvl - LVL_W'(pop) + LVL_W'(push && !full);
  endfunction

  assign sel_data  = (host_addr == OFS_DATA);
  assign sel_addr  = (host_addr == OFS_ADDR);
  assign sel_cfg   = (host_addr == OFS_CFG);
  assign sel_stat  = (host_addr == OFS_STAT);
  assign cfg_rgn   = cfg_q[CFG_RGN_LSB +: RGN_W];
  assign cfg_inc   = cfg_q[CFG_INC_BIT];
  assign rgn_valid = region_ok(cfg_rgn);

  assign ev_data_wr      = host_wr && sel_data && rgn_valid;
  assign ev_data_rd      = host_rd && sel_data;
  assign ev_addr_wr      = host_wr && sel_addr;
  assign ev_cfg_wr       = host_wr && sel_cfg;
  assign ev_stat_wr      = host_wr && sel_stat;
  assign ev_burst_start  = ev_cfg_wr && host_wdata[CFG_BURST_BIT];
  assign ev_burst_cancel = ev_cfg_wr && !host_wdata[CFG_BURST_BIT];
  assign ev_access       = ev_data_wr || ev_fetch_done;

  assign fetch_req   = burst_active && !fifo_full && rgn_valid;
  assign fifo_pop    = ev_data_rd && !fifo_empty;
  assign level_after = level_next(fifo_level, fifo_pop, ev_fetch_done, fifo_full);

  assign wr_cmd.rgn  = cfg_rgn;
  assign wr_cmd.addr = map_addr(cfg_rgn, addr_q);
  assign wr_cmd.data = host_wdata;

  hwin_rdfifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (ev_burst_cancel),
    .push      (ev_fetch_done),
    .push_data (mem_rdata),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .level     (fifo_level),
    .full      (fifo_full),
    .empty     (fifo_empty)
  );

  hwin_burst_ctl #(.MAX_WORDS(FIFO_DEPTH)) u_burst (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (ev_burst_start),
    .cancel     (ev_burst_cancel),
    .len_sel    (len_sel_q),
    .fetch_done (ev_fetch_done),
    .active     (burst_active)
  );

  hwin_mem_port u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_go      (ev_data_wr),
    .wr_cmd     (wr_cmd),
    .fetch_req  (fetch_req),
    .fetch_rgn  (cfg_rgn),
    .fetch_addr (map_addr(cfg_rgn, addr_q)),
    .wr_busy    (wr_busy),
    .fetch_done (ev_fetch_done),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_write  (mem_write),
    .mem_region (mem_region),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      addr_q    <= '0;
      len_sel_q <= '0;
      irq_q     <= 1'b0;
    end else begin
      if (ev_cfg_wr)  cfg_q     <= host_wdata;
      if (ev_stat_wr) len_sel_q <= host_wdata[3:2];
      if (ev_addr_wr)     addr_q <= host_wdata;
      else if (ev_access) addr_q <= step_addr(addr_q, cfg_inc);
      irq_q <= ev_data_wr || ev_burst_start || (ev_data_rd && (level_after != '0));
    end
  end

  assign host_irq = irq_q;

  always_comb begin
    host_rdata = '0;
    if (sel_data)      host_rdata = fifo_empty ? '0 : fifo_head;
    else if (sel_cfg)  host_rdata = cfg_q;
    else if (sel_stat) host_rdata = make_status(len_sel_q, fifo_full, fifo_empty);
  end

  // R3: no request is ever raised toward an undefined region
  p_region_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> region_ok(mem_region))
    else $error("request toward an undefined region");

  // R4: the address wraps within 16 bits
  p_addr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_access && cfg_inc && (addr_q == 16'hFFFF) && !ev_addr_wr) |=> (addr_q == 16'h0000))
    else $error("address did not wrap");

  // R5: input assumption, data writes are spaced past a pending write
  p_wr_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data_wr |-> !wr_busy)
    else $error("data write while a write is pending");

  // R9: an empty FIFO reads as zero
  p_empty_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_rd && fifo_empty) |-> (host_rdata == '0))
    else $error("empty data read not zero");

  // R10: after a cancel no prefetch request is outstanding
  p_cancel_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_burst_cancel |=> !(mem_valid && !mem_write))
    else $error("prefetch after cancel");

  // R11: status bit 8 always reads one
  p_stat_fixed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && sel_stat) |-> host_rdata[8])
    else $error("status bit 8 low");

  // R12: a burst start raises the interrupt one cycle later
  p_irq_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_burst_start |=> host_irq)
    else $error("no interrupt on burst start");
endmodule

// File: tb/hwin_burst_port_tb.sv
module hwin_burst_port_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0, host_rd = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_irq;
  logic        mem_valid, mem_write;
  logic        mem_ready = 1'b0;
  logic [2:0]  mem_region;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int checks = 0;
  int errors = 0;
  string ctx = "";

  always #4 clk = ~clk;

  function automatic logic [15:0] rd_fn(input logic [2:0] r, input logic [15:0] a);
    return a ^ {r, 13'h00A5};
  endfunction

  assign mem_rdata = rd_fn(mem_region, mem_addr);

  hwin_burst_port dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_irq(host_irq), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_write(mem_write), .mem_region(mem_region), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // ---------------- reference model state ----------------
  logic [15:0] m_cfg = '0, m_addr = '0;
  logic [1:0]  m_len = '0;
  int          m_rem = 0;           // -1 = endless
  logic [15:0] m_q[$];
  logic [34:0] m_wq[$];
  logic        irq_exp = 1'b0;

  function automatic logic m_rgn_ok(input logic [2:0] r);
    return r == 3'd0 || r == 3'd1 || r == 3'd5 || r == 3'd7;
  endfunction
  function automatic logic [15:0] m_map(input logic [2:0] r, input logic [15:0] a);
    return (r == 3'd1) ? {5'b0, a[10:0]} : a;
  endfunction

  task automatic chk(input logic ok, input string what, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", ctx, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0]  rg;
      logic        hs;
      int          sz;
      logic [15:0] ev;
      logic        irq_n;
      rg = m_cfg[14:12];
      hs = mem_valid && mem_ready;
      sz = m_q.size();
      irq_n = 1'b0;
      chk(host_irq === irq_exp, "R12 interrupt pulse", 36'(host_irq), 36'(irq_exp));
      if (host_rd) begin
        case (host_addr)
          6'h00: begin
            ev = (sz != 0) ? m_q[0] : 16'h0000;
            chk(host_rdata === ev, (sz != 0) ? "R8 data read" : "R9 empty data read",
                36'(host_rdata), 36'(ev));
            if (sz != 0) void'(m_q.pop_front());
          end
          6'h04: chk(host_rdata === 16'h0, "R13 address read", 36'(host_rdata), 36'h0);
          6'h08: chk(host_rdata === m_cfg, "R13 config read", 36'(host_rdata), 36'(m_cfg));
          6'h0C: begin
            ev = 16'h0100 | {8'h0, 1'b0, (sz != 0), (sz == DEPTH), 1'b0, m_len, 1'b0, (sz != 0)};
            chk(host_rdata === ev, "R11 status", 36'(host_rdata), 36'(ev));
          end
          default: ;
        endcase
      end
      if (hs && mem_write) begin
        if (m_wq.size() == 0)
          chk(1'b0, "R3 unexpected write request", {1'b0, mem_region, mem_addr, mem_wdata}, 36'h0);
        else begin
          logic [34:0] e;
          e = m_wq.pop_front();
          chk({mem_region, mem_addr, mem_wdata} === e, "R2 R4 R5 write request",
              36'({mem_region, mem_addr, mem_wdata}), 36'(e));
        end
      end
      if (hs && !mem_write) begin
        chk(m_rem != 0 && sz < DEPTH && m_rgn_ok(rg), "R6 R7 fetch permitted",
            36'(sz), 36'(m_rem));
        ev = m_map(rg, m_addr);
        chk(mem_region === rg && mem_addr === ev, "R2 R4 fetch address",
            36'({mem_region, mem_addr}), 36'({rg, ev}));
        m_q.push_back(rd_fn(rg, ev));
        if (m_rem > 0) m_rem--;
        m_addr = m_addr + 16'(m_cfg[1]);
      end
      if (host_rd && host_addr == 6'h00 && m_q.size() != 0) irq_n = 1'b1;
      if (host_wr) begin
        case (host_addr)
          6'h00: if (m_rgn_ok(rg)) begin
            m_wq.push_back({rg, m_map(rg, m_addr), host_wdata});
            m_addr = m_addr + 16'(m_cfg[1]);
            irq_n = 1'b1;
          end
          6'h04: m_addr = host_wdata;
          6'h08: begin
            m_cfg = host_wdata;
            if (host_wdata[4]) begin
              m_rem = (m_len == 2'd0) ? 1 : (m_len == 2'd1) ? 8 : (m_len == 2'd2) ? 16 : -1;
              irq_n = 1'b1;
            end else begin
              m_rem = 0;
              m_q.delete();
            end
          end
          6'h0C: m_len = host_wdata[3:2];
          default: ;
        endcase
      end
      irq_exp = irq_n;
    end
  end

  // memory acceptance pattern: stalls one cycle in three
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk); #1;
      cyc++;
      mem_ready = (cyc % 3) != 2;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask
  task automatic hwr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(posedge clk); #1;
    host_wr = 1'b0;
  endtask
  task automatic hrd(input logic [5:0] a);
    @(posedge clk); #1;
    host_rd = 1'b1; host_addr = a;
    @(posedge clk); #1;
    host_rd = 1'b0;
  endtask
  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      idle(4);
      hrd(6'h00);
    end
  endtask

  initial begin
    idle(3);
    #1 rst_n = 1'b1;
    ctx = "R1";
    @(negedge clk);
    chk(mem_valid === 1'b0, "R1 no request after reset", 36'(mem_valid), 36'h0);
    chk(host_irq === 1'b0, "R1 interrupt low after reset", 36'(host_irq), 36'h0);
    hrd(6'h0C);
    hrd(6'h08);

    ctx = "R5 R4 R13";
    hwr(6'h04, 16'h0010);
    hrd(6'h04);
    hwr(6'h08, 16'h0002);               // data region, step on
    hrd(6'h08);
    for (int i = 0; i < 3; i++) begin
      hwr(6'h00, 16'hA000 + 16'(i));
      idle(4);
    end

    ctx = "R4 no-step";
    hwr(6'h08, 16'h5000);               // program region, step off
    hwr(6'h00, 16'h1111); idle(4);
    hwr(6'h00, 16'h2222); idle(4);

    ctx = "R2 register space";
    hwr(6'h08, 16'h1002);
    hwr(6'h04, 16'hF805);
    hwr(6'h00, 16'h3333); idle(4);

    ctx = "R3 undefined region";
    hwr(6'h08, 16'h3002);
    hwr(6'h04, 16'h0040);
    hwr(6'h00, 16'hDEAD); idle(4);
    hwr(6'h08, 16'h7002);               // address must still be 0x0040
    hwr(6'h00, 16'h4444); idle(4);

    ctx = "R4 wrap";
    hwr(6'h04, 16'hFFFF);
    hwr(6'h00, 16'h5555); idle(4);
    hwr(6'h00, 16'h6666); idle(4);

    ctx = "R6 one word";
    hwr(6'h0C, 16'h0000);
    hwr(6'h04, 16'h0100);
    hwr(6'h08, 16'h5012);
    idle(20);
    hrd(6'h0C);
    hrd(6'h00);
    ctx = "R9";
    hrd(6'h00);
    hrd(6'h0C);

    ctx = "R6 eight words";
    hwr(6'h0C, 16'h0004);
    hwr(6'h04, 16'h0200);
    hwr(6'h08, 16'h0012);
    idle(40);
    hrd(6'h0C);
    drain(8);
    hrd(6'h0C);

    ctx = "R6 R7 sixteen words";
    hwr(6'h0C, 16'h0008);
    hwr(6'h04, 16'h0300);
    hwr(6'h08, 16'h7012);
    idle(60);
    hrd(6'h0C);                          // full
    hrd(6'h00);
    idle(10);
    hrd(6'h0C);                          // 15 left, no refill
    drain(15);
    hrd(6'h00);

    ctx = "R7 R8 endless";
    hwr(6'h0C, 16'h000C);
    hwr(6'h04, 16'hFFF8);
    hwr(6'h08, 16'h0012);
    idle(60);
    hrd(6'h0C);
    drain(24);
    idle(10);
    hrd(6'h0C);

    ctx = "R10 cancel";
    hwr(6'h08, 16'h0002);
    idle(10);
    hrd(6'h0C);
    hrd(6'h00);

    ctx = "R2 R10 cancel mid-burst";
    hwr(6'h0C, 16'h0008);
    hwr(6'h04, 16'h1234);
    hwr(6'h08, 16'h1012);
    idle(5);
    hwr(6'h08, 16'h1002);
    idle(10);
    hrd(6'h0C);
    hrd(6'h00);

    idle(5);
    ctx = "R5";
    chk(m_wq.size() == 0, "R5 all writes issued", 36'(m_wq.size()), 36'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule